// File: doc/BRIEF.md
# Calibration-Strobe and Trigger Burst Sequencer

This block drives one serial command line toward a device under test. A single start pulse launches a burst of identical sequences. Each sequence may open with a calibration-strobe command and then carries a trigger command. Both commands are fixed bit patterns, given as parameters, and are shifted out MSB first. The clock runs at 40 MHz, so one cycle is 25 ns.

Four setup inputs are captured when a burst is accepted: the sequence count (16 bits), the start-to-start spacing of sequences (16 bits, in cycles), the strobe-start-to-trigger-start delay (8 bits, in cycles), and a strobe enable. Both spacings are measured between command starts, so the bits of a command count toward them. Busy stays high from the accepting edge until the last trigger bit has left the line.

The spacing has to leave room for downstream processing of the device's response. With every channel reporting, that processing needs about 64 cycles on top of the command bits.

Top module: `cal_trig_burst`

## Requirements
- R1: After reset, busy and the command line are both 0.
- R2: Commands go out MSB first, one bit per cycle, and the line idles at 0. Take the edge that accepts start as E, and number the cycles that follow it from 1. The first bit of the command loaded for sequence k then shows in cycle 2 + k·P + offset, where the offset is 0 for the strobe and D for the trigger.
- R3: Sequence k begins at k·P cycles after sequence 0. A period P of 0 or 1 starts a new sequence every cycle.
- R4: When the strobe enable is 0, no strobe is sent and the trigger starts at the beginning of every sequence.
- R5: A start with a count of 0 sends nothing, and busy stays low.
- R6: Busy is high in cycles 1 through count·P, and after that for as long as command bits are still shifting. It is high in every cycle where the line is 1.
- R7: A start pulse while busy is high is ignored and does not change the burst in progress.
- R8: The count, period, delay and enable are captured at the accepting edge. Changes to them during a burst have no effect on that burst.
- R9: A command that starts while another is still shifting cuts the earlier one short. The new pattern begins at once, so a delay shorter than the strobe length truncates the strobe.
- R10: With the strobe enabled, a delay of 0 sends only the trigger at the sequence start. A delay of P or more sends no trigger in that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a burst (taken only while idle) |
| cfg_count | input | 16 | Number of sequences in the burst |
| cfg_period | input | 16 | Start-to-start spacing of sequences, in cycles |
| cfg_delay | input | 8 | Strobe start to trigger start, in cycles |
| cfg_strobe_en | input | 1 | 1 puts a strobe command at the start of each sequence |
| busy | output | 1 | Burst in progress or bits still shifting |
| cmd_out | output | 1 | Serial command line |

## Verification
Two loads can fall in the same cycle or overlap in time. A trigger can be due while the strobe is still shifting, or both can be due in the very cycle a sequence opens. The bench provokes both cases with a delay shorter than the strobe length and with a delay of 0. It also uses a period of 0, which restarts the trigger in every cycle. Each case is judged bit by bit against a timeline built from the requirements, in which the later load always replaces the bits still waiting in the shifter.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_STRB = 2'd1,
      CMD_TRIG = 2'd2
   } cmd_kind_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/burst_seq_timer.sv
module burst_seq_timer #(
   parameter int CNT_W    = 16,
   parameter int PERIOD_W = 16,
   parameter int DLY_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic [CNT_W-1:0]    cnt_in,
   input  logic [PERIOD_W-1:0] per_in,
   input  logic [DLY_W-1:0]    dly_in,
   input  logic                en_in,
   output logic                run,
   output logic                strb_go,
   output logic                trig_go
);

   if (PERIOD_W < DLY_W) begin : g_bad_widths
      $error("burst_seq_timer: PERIOD_W must be at least DLY_W");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("burst_seq_timer: CNT_W must be positive");
   end

   logic [PERIOD_W-1:0] ph;
   logic [PERIOD_W-1:0] per_q;
   logic [DLY_W-1:0]    dly_q;
   logic                en_q;
   logic [CNT_W-1:0]    left;
   logic [PERIOD_W:0]   ph_inc;
   logic                wrap;

   assign ph_inc = {1'b0, ph} + (PERIOD_W+1)'(1);
   assign wrap   = (ph_inc >= {1'b0, per_q});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run   <= 1'b0;
         ph    <= '0;
         per_q <= '0;
         dly_q <= '0;
         en_q  <= 1'b0;
         left  <= '0;
      end else if (go) begin
         run   <= 1'b1;
         ph    <= '0;
         left  <= cnt_in;
         per_q <= per_in;
         dly_q <= dly_in;
         en_q  <= en_in;
      end else if (run) begin
         if (wrap) begin
            ph   <= '0;
            left <= left - CNT_W'(1);
            if (left == CNT_W'(1)) run <= 1'b0;
         end else begin
            ph <= ph_inc[PERIOD_W-1:0];
         end
      end
   end

   assign strb_go = run && en_q && (ph == '0);
   assign trig_go = run && (en_q ? (ph == PERIOD_W'(dly_q)) : (ph == '0));

   // R7: the top never re-launches a burst in progress
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> !go);
   // R5: a running burst always has sequences left
   a_r5_left_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (left != '0));
   // R3: phase stays inside the captured period
   a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (run && per_q > PERIOD_W'(1)) |-> (ph < per_q));
   // R8: captured settings hold while running
   a_r8_settings_held: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !go) |=> ($stable(per_q) && $stable(dly_q) && $stable(en_q)));

endmodule

// File: rtl/burst_cmd_shifter.sv
module burst_cmd_shifter
   import burst_seq_pkg::*;
#(
   parameter int                  STRB_LEN = 9,
   parameter logic [STRB_LEN-1:0] STRB_PAT = 9'b101100101,
   parameter int                  TRIG_LEN = 4,
   parameter logic [TRIG_LEN-1:0] TRIG_PAT = 4'b1101
) (
   input  logic      clk,
   input  logic      rst_n,
   input  cmd_kind_e kind,
   output logic      line,
   output logic      active
);

   localparam int SH_W = max2(STRB_LEN, TRIG_LEN);
   localparam int RW   = $clog2(SH_W + 1);
   localparam logic [SH_W-1:0] STRB_ALIGN = SH_W'(STRB_PAT) << (SH_W - STRB_LEN);
   localparam logic [SH_W-1:0] TRIG_ALIGN = SH_W'(TRIG_PAT) << (SH_W - TRIG_LEN);

   if (STRB_LEN < 1 || TRIG_LEN < 1) begin : g_bad_len
      $error("burst_cmd_shifter: command lengths must be positive");
   end

   logic [SH_W-1:0] sh;
   logic [RW-1:0]   rem;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh  <= '0;
         rem <= '0;
      end else begin
         unique case (kind)
            CMD_TRIG: begin
               sh  <= TRIG_ALIGN;
               rem <= RW'(TRIG_LEN);
            end
            CMD_STRB: begin
               sh  <= STRB_ALIGN;
               rem <= RW'(STRB_LEN);
            end
            default: begin
               if (rem != '0) begin
                  sh  <= sh << 1;
                  rem <= rem - RW'(1);
               end
            end
         endcase
      end
   end

   assign active = (rem != '0);
   assign line   = active && sh[SH_W-1];

   // R2: a trigger load shows its MSB on the next cycle
   a_r2_trig_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CMD_TRIG) |=> (line == TRIG_PAT[TRIG_LEN-1]));
   // R2: a strobe load shows its MSB on the next cycle
   a_r2_strb_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CMD_STRB) |=> (line == STRB_PAT[STRB_LEN-1]));
   // R6: without a load, the remaining bit count only falls by one
   a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (active && kind == CMD_NONE) |=> (rem == $past(rem) - RW'(1)));

endmodule

// File: rtl/cal_trig_burst.sv
module cal_trig_burst
   import burst_seq_pkg::*;
#(
   parameter int                  CNT_W         = 16,
   parameter int                  PERIOD_W      = 16,
   parameter int                  DLY_W         = 8,
   parameter bit                  ENABLE_STROBE = 1'b1,
   parameter int                  STRB_LEN      = 9,
   parameter logic [STRB_LEN-1:0] STRB_PAT      = 9'b101100101,
   parameter int                  TRIG_LEN      = 4,
   parameter logic [TRIG_LEN-1:0] TRIG_PAT      = 4'b1101
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [CNT_W-1:0]    cfg_count,
   input  logic [PERIOD_W-1:0] cfg_period,
   input  logic [DLY_W-1:0]    cfg_delay,
   input  logic                cfg_strobe_en,
   output logic                busy,
   output logic                cmd_out
);

   logic      go;
   logic      run;
   logic      strb_go;
   logic      trig_go;
   logic      strb_allowed;
   logic      shifting;
   cmd_kind_e kind;

   assign go = start && !busy && (cfg_count != '0);

   generate
      if (ENABLE_STROBE) begin : g_strobe
         assign strb_allowed = cfg_strobe_en;
      end else begin : g_no_strobe
         assign strb_allowed = 1'b0;
      end
   endgenerate

   burst_seq_timer #(
      .CNT_W   (CNT_W),
      .PERIOD_W(PERIOD_W),
      .DLY_W   (DLY_W)
   ) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (go),
      .cnt_in (cfg_count),
      .per_in (cfg_period),
      .dly_in (cfg_delay),
      .en_in  (strb_allowed),
      .run    (run),
      .strb_go(strb_go),
      .trig_go(trig_go)
   );

   always_comb begin
      if (trig_go)      kind = CMD_TRIG;
      else if (strb_go) kind = CMD_STRB;
      else              kind = CMD_NONE;
   end

   burst_cmd_shifter #(
      .STRB_LEN(STRB_LEN),
      .STRB_PAT(STRB_PAT),
      .TRIG_LEN(TRIG_LEN),
      .TRIG_PAT(TRIG_PAT)
   ) i_shifter (
      .clk   (clk),
      .rst_n (rst_n),
      .kind  (kind),
      .line  (cmd_out),
      .active(shifting)
   );

   assign busy = run || shifting;

   // R6: the line is never high outside busy
   a_r6_line_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_out |-> busy);
   // R5: a zero-count start leaves the block idle
   a_r5_zero_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && cfg_count == '0) |=> !busy);
   // R6: an accepted start raises busy on the next cycle
   a_r6_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && cfg_count != '0) |=> busy);

endmodule

// File: tb/test_cal_trig_burst.sv
`timescale 1ns/1ps
module test_cal_trig_burst;

   localparam int              S_LEN = 9;
   localparam logic [S_LEN-1:0] S_PAT = 9'b101100101;
   localparam int              T_LEN = 4;
   localparam logic [T_LEN-1:0] T_PAT = 4'b1101;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] cfg_count = '0;
   logic [15:0] cfg_period = '0;
   logic [7:0]  cfg_delay = '0;
   logic        cfg_strobe_en = 1'b0;
   logic        busy;
   logic        cmd_out;

   typedef struct {
      logic  line;
      logic  bsy;
      int    cyc;
      string tag;
   } item_t;

   item_t q[$];
   bit    armed = 1'b0;
   bit    done = 1'b0;
   int    checks = 0;
   int    failures = 0;

   always #2 clk = ~clk;

   cal_trig_burst #(
      .STRB_LEN(S_LEN), .STRB_PAT(S_PAT),
      .TRIG_LEN(T_LEN), .TRIG_PAT(T_PAT)
   ) i_cal_trig_burst (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_count(cfg_count), .cfg_period(cfg_period),
      .cfg_delay(cfg_delay), .cfg_strobe_en(cfg_strobe_en),
      .busy(busy), .cmd_out(cmd_out)
   );

   // monitor: pop one expected item per cycle and compare
   always @(negedge clk) begin
      if (armed && q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         checks++;
         if (cmd_out !== it.line || busy !== it.bsy) begin
            failures++;
            $display("FAIL %s cycle %0d: line=%b busy=%b expected line=%b busy=%b",
                     it.tag, it.cyc, cmd_out, busy, it.line, it.bsy);
         end
      end
   end

   // driver: build the expected timeline from the requirements, then launch
   task automatic run_burst(input int cnt, input int per, input int dly,
                            input bit en, input string tag,
                            input bit repulse, input bit mutate);
      int lk[int];
      int peff = (per == 0) ? 1 : per;
      int horizon = cnt * peff + S_LEN + T_LEN + 3;
      int last_l = -1000;
      int kind = 0;
      for (int k = 0; k < cnt; k++) begin
         int s = 1 + k * peff;
         if (en) begin
            lk[s] = 1;
            if (dly < peff) lk[s + dly] = 2;
         end else begin
            lk[s] = 2;
         end
      end
      for (int c = 1; c <= horizon; c++) begin
         item_t it;
         int idx;
         int len;
         if (lk.exists(c - 1)) begin
            last_l = c - 1;
            kind = lk[c - 1];
         end
         idx = c - last_l - 1;
         len = (kind == 1) ? S_LEN : T_LEN;
         it.line = 1'b0;
         if (kind != 0 && idx < len)
            it.line = (kind == 1) ? S_PAT[S_LEN-1-idx] : T_PAT[T_LEN-1-idx];
         it.bsy = (c <= cnt * peff) || (kind != 0 && idx < len);
         it.cyc = c;
         it.tag = tag;
         q.push_back(it);
      end
      cfg_count = 16'(cnt);
      cfg_period = 16'(per);
      cfg_delay = 8'(dly);
      cfg_strobe_en = en;
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      armed = 1'b1;
      if (mutate) begin
         cfg_count = 16'd1;
         cfg_period = 16'd7;
         cfg_delay = 8'd2;
         cfg_strobe_en = ~en;
      end
      if (repulse) begin
         repeat (3) @(posedge clk);
         #1 start = 1'b1;
         cfg_period = 16'd5;
         @(posedge clk);
         #1 start = 1'b0;
      end
      wait (q.size() == 0);
      @(negedge clk);
      armed = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      checks++;
      if (busy !== 1'b0 || cmd_out !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset: busy=%b line=%b expected busy=0 line=0", busy, cmd_out);
      end
      run_burst(3, 40, 15, 1'b1, "R2 R3 R6 strobe+trigger", 1'b0, 1'b0);
      run_burst(2, 20, 7, 1'b0, "R4 strobe disabled", 1'b0, 1'b0);
      run_burst(0, 20, 7, 1'b1, "R5 zero count", 1'b0, 1'b0);
      run_burst(4, 25, 12, 1'b1, "R7 start while busy", 1'b1, 1'b0);
      run_burst(3, 30, 10, 1'b1, "R8 settings changed mid-burst", 1'b0, 1'b1);
      run_burst(2, 30, 4, 1'b1, "R9 trigger truncates strobe", 1'b0, 1'b0);
      run_burst(2, 16, 0, 1'b1, "R10 delay zero", 1'b0, 1'b0);
      run_burst(2, 16, 20, 1'b1, "R10 delay past period", 1'b0, 1'b0);
      run_burst(3, 0, 0, 1'b0, "R3 period zero", 1'b0, 1'b0);
      run_burst(2, 3, 1, 1'b1, "R9 R3 short period overlap", 1'b0, 1'b0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule